// File: doc/BRIEF.md
# Dual-Clock Mixed-Aspect RAM with Parity

This block is a true dual-port synchronous memory holding 16384 data bits and 2048 parity bits. Port A and port B each have their own clock, enable, write enable, synchronous output reset, address, write data, write parity, read data and read parity. The two clocks may be unrelated.

Each port picks its own data width through a parameter, from 1 to 32 bits in powers of two. Both ports see the same storage, so a producer can write bytes on one side while a consumer reads whole 32-bit words on the other. Ports of 8 bits and wider carry one parity bit per data byte. Narrower ports have a single parity pin on each side that is unused. The storage starts with the contents given by two parameters.

Top module: `dual_aspect_ram`

## Requirements
- R1: A port of width W (1, 2, 4, 8, 16 or 32) has 16384/W locations and 14 - log2(W) address bits. Its highest address reaches the last W bits of the storage.
- R2: Data bit i at address n of a W-bit port is global storage bit n*W + i. For a narrow port this means address k is lane (k mod ratio) of wide word k/ratio, with lane 0 in the least significant bits.
- R3: A port of width 8 or more carries W/8 parity bits. Parity bit j at address n is global parity bit n*(W/8) + j, and it goes with data byte j. A narrower port drives its parity output to 0 and ignores its parity input.
- R4: An enabled write stores the data and parity. On the same clock edge it loads that data and parity into the port's output register (write-first).
- R5: An enabled read loads the stored word and its parity into the output register at the sampling edge. It is visible at the port from that edge until the next enabled operation or reset.
- R6: While the enable is low, a write enable has no effect on the storage, and the output register keeps its value.
- R7: With the reset input high, a clock edge clears that port's data and parity outputs to 0. The reset does not change the storage.
- R8: Before any write, the storage holds the data-initialisation parameter, whose bit m is global data bit m, and the parity-initialisation parameter, whose bit m is global parity bit m.
- R9: Each port runs only on its own clock. A write completed on one port is returned by a read on the other port at any later edge of that port's clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| en_a | input | 1 | Port A operation enable |
| we_a | input | 1 | Port A write enable |
| rst_a | input | 1 | Port A synchronous output reset |
| addr_a | input | 14-log2(WIDTH_A) | Port A address |
| din_a | input | WIDTH_A | Port A write data |
| pin_a | input | max(1,WIDTH_A/8) | Port A write parity |
| dout_a | output | WIDTH_A | Port A read data register |
| pout_a | output | max(1,WIDTH_A/8) | Port A read parity register |
| clk_b | input | 1 | Port B clock |
| en_b | input | 1 | Port B operation enable |
| we_b | input | 1 | Port B write enable |
| rst_b | input | 1 | Port B synchronous output reset |
| addr_b | input | 14-log2(WIDTH_B) | Port B address |
| din_b | input | WIDTH_B | Port B write data |
| pin_b | input | max(1,WIDTH_B/8) | Port B write parity |
| dout_b | output | WIDTH_B | Port B read data register |
| pout_b | output | max(1,WIDTH_B/8) | Port B read parity register |

## Verification
A wrong lane offset or row index stays hidden inside the array until a read. It shows up one clock after the first enabled read that touches the affected bits, most clearly when the other port reads back data written at a different width. A corrupted bank that cancels a stored value shows up as wrong data or parity on the first cross-port read of those bits. A write-enable leak or a failing output hold shows up on the next read of the same address, or on the next sample of the idle output. The bench therefore writes at one width, reads back at the other, and compares every output register one cycle after each operation.

// File: rtl/dual_aspect_ram.sv
module dual_aspect_ram #(
  parameter int WIDTH_A = 8,
  parameter int WIDTH_B = 32,
  parameter logic [16383:0] INIT_DATA = '0,
  parameter logic [2047:0]  INIT_PAR  = '0,
  localparam int AW_A = 14 - $clog2(WIDTH_A),
  localparam int AW_B = 14 - $clog2(WIDTH_B),
  localparam int PW_A = (WIDTH_A >= 8) ? WIDTH_A / 8 : 1,
  localparam int PW_B = (WIDTH_B >= 8) ? WIDTH_B / 8 : 1
) (
  input  logic              clk_a,
  input  logic              en_a,
  input  logic              we_a,
  input  logic              rst_a,
  input  logic [AW_A-1:0]   addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  input  logic [PW_A-1:0]   pin_a,
  output logic [WIDTH_A-1:0] dout_a,
  output logic [PW_A-1:0]   pout_a,
  input  logic              clk_b,
  input  logic              en_b,
  input  logic              we_b,
  input  logic              rst_b,
  input  logic [AW_B-1:0]   addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  input  logic [PW_B-1:0]   pin_b,
  output logic [WIDTH_B-1:0] dout_b,
  output logic [PW_B-1:0]   pout_b
);
  localparam int ROWS = 512;
  localparam int RA = 32 / WIDTH_A;
  localparam int RB = 32 / WIDTH_B;
  localparam int SA = $clog2(RA);
  localparam int SB = $clog2(RB);

  // Each bit is the XOR of a bank owned by port A and one owned by port B.
  logic [31:0] bank_a [ROWS];
  logic [31:0] bank_b [ROWS];
  logic [3:0]  pbank_a [ROWS];
  logic [3:0]  pbank_b [ROWS];

  initial begin
    for (int r = 0; r < ROWS; r++) begin
      bank_a[r]  = INIT_DATA[r*32 +: 32];
      bank_b[r]  = '0;
      pbank_a[r] = INIT_PAR[r*4 +: 4];
      pbank_b[r] = '0;
    end
  end

  logic [8:0] row_a, row_b;
  logic [4:0] off_a, off_b;
  logic [WIDTH_A-1:0] rd_a;
  logic [WIDTH_B-1:0] rd_b;

  assign row_a = 9'(addr_a >> SA);
  assign row_b = 9'(addr_b >> SB);
  assign off_a = 5'((int'(addr_a) % RA) * WIDTH_A);
  assign off_b = 5'((int'(addr_b) % RB) * WIDTH_B);
  assign rd_a  = bank_a[row_a][off_a +: WIDTH_A] ^ bank_b[row_a][off_a +: WIDTH_A];
  assign rd_b  = bank_a[row_b][off_b +: WIDTH_B] ^ bank_b[row_b][off_b +: WIDTH_B];

  always_ff @(posedge clk_a) begin
    if (en_a && we_a)
      bank_a[row_a][off_a +: WIDTH_A] <= din_a ^ bank_b[row_a][off_a +: WIDTH_A];
    if (rst_a)     dout_a <= '0;
    else if (en_a) dout_a <= we_a ? din_a : rd_a;
  end

  always_ff @(posedge clk_b) begin
    if (en_b && we_b)
      bank_b[row_b][off_b +: WIDTH_B] <= din_b ^ bank_a[row_b][off_b +: WIDTH_B];
    if (rst_b)     dout_b <= '0;
    else if (en_b) dout_b <= we_b ? din_b : rd_b;
  end

  if (WIDTH_A >= 8) begin : g_par_a
    localparam int PA = WIDTH_A / 8;
    logic [1:0] poff;
    logic [PA-1:0] prd;
    assign poff = 2'((int'(addr_a) % RA) * PA);
    assign prd  = pbank_a[row_a][poff +: PA] ^ pbank_b[row_a][poff +: PA];
    always_ff @(posedge clk_a) begin
      if (en_a && we_a)
        pbank_a[row_a][poff +: PA] <= pin_a ^ pbank_b[row_a][poff +: PA];
      if (rst_a)     pout_a <= '0;
      else if (en_a) pout_a <= we_a ? pin_a : prd;
    end
  end else begin : g_nopar_a
    logic unused_pin_a;
    assign unused_pin_a = ^pin_a;
    assign pout_a = '0;
  end

  if (WIDTH_B >= 8) begin : g_par_b
    localparam int PB = WIDTH_B / 8;
    logic [1:0] poff;
    logic [PB-1:0] prd;
    assign poff = 2'((int'(addr_b) % RB) * PB);
    assign prd  = pbank_a[row_b][poff +: PB] ^ pbank_b[row_b][poff +: PB];
    always_ff @(posedge clk_b) begin
      if (en_b && we_b)
        pbank_b[row_b][poff +: PB] <= pin_b ^ pbank_a[row_b][poff +: PB];
      if (rst_b)     pout_b <= '0;
      else if (en_b) pout_b <= we_b ? pin_b : prd;
    end
  end else begin : g_nopar_b
    logic unused_pin_b;
    assign unused_pin_b = ^pin_b;
    assign pout_b = '0;
  end

  p_wr_first_a_r4: assert property (@(posedge clk_a) disable iff (rst_a)
    en_a && we_a |=> dout_a == $past(din_a));
  p_wr_first_b_r4: assert property (@(posedge clk_b) disable iff (rst_b)
    en_b && we_b |=> dout_b == $past(din_b));
  p_read_a_r5: assert property (@(posedge clk_a) disable iff (rst_a)
    en_a && !we_a |=> dout_a == $past(rd_a));
  p_read_b_r5: assert property (@(posedge clk_b) disable iff (rst_b)
    en_b && !we_b |=> dout_b == $past(rd_b));
  p_hold_a_r6: assert property (@(posedge clk_a) disable iff (rst_a)
    !en_a |=> $stable(dout_a) && $stable(pout_a));
  p_hold_b_r6: assert property (@(posedge clk_b) disable iff (rst_b)
    !en_b |=> $stable(dout_b) && $stable(pout_b));
  p_rst_a_r7: assert property (@(posedge clk_a)
    rst_a |=> dout_a == '0 && pout_a == '0);
  p_rst_b_r7: assert property (@(posedge clk_b)
    rst_b |=> dout_b == '0 && pout_b == '0);
endmodule

// File: tb/dual_aspect_ram_tb.sv
module dual_aspect_ram_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [16383:0] INIT_D = {256{64'h0F1E_2D3C_4B5A_6978}};
  localparam logic [2047:0]  INIT_P = {256{8'h96}};
  localparam int WD [4] = '{8, 32, 1, 16};

  logic clk_a = 0, clk_b = 0;
  always #2 clk_a = ~clk_a;
  always #3 clk_b = ~clk_b;

  logic        en_v [4];
  logic        we_v [4];
  logic        rs_v [4];
  logic [13:0] ad_v [4];
  logic [31:0] dn_v [4];
  logic [3:0]  pn_v [4];

  logic [7:0]  q0;  logic       q0p;
  logic [31:0] q1;  logic [3:0] q1p;
  logic        q2;  logic       q2p;
  logic [15:0] q3;  logic [1:0] q3p;

  dual_aspect_ram #(.WIDTH_A(8), .WIDTH_B(32), .INIT_DATA(INIT_D), .INIT_PAR(INIT_P)) u_dut (
    .clk_a(clk_a), .en_a(en_v[0]), .we_a(we_v[0]), .rst_a(rs_v[0]), .addr_a(ad_v[0][10:0]),
    .din_a(dn_v[0][7:0]), .pin_a(pn_v[0][0:0]), .dout_a(q0), .pout_a(q0p),
    .clk_b(clk_b), .en_b(en_v[1]), .we_b(we_v[1]), .rst_b(rs_v[1]), .addr_b(ad_v[1][8:0]),
    .din_b(dn_v[1]), .pin_b(pn_v[1]), .dout_b(q1), .pout_b(q1p));

  dual_aspect_ram #(.WIDTH_A(1), .WIDTH_B(16), .INIT_DATA(INIT_D), .INIT_PAR(INIT_P)) u_dut_n (
    .clk_a(clk_a), .en_a(en_v[2]), .we_a(we_v[2]), .rst_a(rs_v[2]), .addr_a(ad_v[2]),
    .din_a(dn_v[2][0:0]), .pin_a(pn_v[2][0:0]), .dout_a(q2), .pout_a(q2p),
    .clk_b(clk_b), .en_b(en_v[3]), .we_b(we_v[3]), .rst_b(rs_v[3]), .addr_b(ad_v[3][9:0]),
    .din_b(dn_v[3][15:0]), .pin_b(pn_v[3][1:0]), .dout_b(q3), .pout_b(q3p));

  typedef struct {logic [31:0] d; logic [3:0] p; string tag;} item_t;
  item_t sbq [4][$];
  logic [16383:0] m_d [2];
  logic [2047:0]  m_p [2];
  logic [31:0] last_d [4];
  logic [3:0]  last_p [4];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [35:0] outv(int p);
    case (p)
      0: return {3'b0, q0p, 24'b0, q0};
      1: return {q1p, q1};
      2: return {3'b0, q2p, 31'b0, q2};
      default: return {2'b0, q3p, 16'b0, q3};
    endcase
  endfunction

  task automatic chk(int p);
    item_t it;
    logic [35:0] o;
    if (sbq[p].size() == 0) return;
    it = sbq[p].pop_front();
    o = outv(p);
    n_chk++;
    if (o !== {it.p, it.d}) begin
      n_fail++;
      $display("FAIL %s port%0d: actual d=%h p=%h expected d=%h p=%h",
               it.tag, p, o[31:0], o[35:32], it.d, it.p);
    end
  endtask

  always @(negedge clk_a) begin chk(0); chk(2); end
  always @(negedge clk_b) begin chk(1); chk(3); end

  task automatic op(int p, bit en, bit we, bit rs, int addr, logic [31:0] d,
                    logic [3:0] pr, string tag);
    int w = WD[p];
    int pw = (w >= 8) ? w / 8 : 0;
    int k = p / 2;
    logic [31:0] msk = 32'((64'd1 << w) - 1);
    logic [3:0] pm = 4'((1 << pw) - 1);
    item_t it;
    if (p % 2 == 0) @(negedge clk_a); else @(negedge clk_b);
    en_v[p] = en; we_v[p] = we; rs_v[p] = rs; ad_v[p] = 14'(addr);
    dn_v[p] = d & msk; pn_v[p] = (pw > 0) ? (pr & pm) : pr;
    if (p % 2 == 0) @(posedge clk_a); else @(posedge clk_b);
    it.tag = tag; it.d = '0; it.p = '0;
    if (rs) ;
    else if (!en) begin it.d = last_d[p]; it.p = last_p[p]; end
    else if (we) begin it.d = d & msk; it.p = pr & pm; end
    else begin
      for (int i = 0; i < w; i++) it.d[i] = m_d[k][addr*w + i];
      for (int j = 0; j < pw; j++) it.p[j] = m_p[k][addr*pw + j];
    end
    if (en && we) begin
      for (int i = 0; i < w; i++) m_d[k][addr*w + i] = d[i];
      for (int j = 0; j < pw; j++) m_p[k][addr*pw + j] = pr[j];
    end
    last_d[p] = it.d; last_p[p] = it.p;
    sbq[p].push_back(it);
    #0.5;
    en_v[p] = 0; we_v[p] = 0; rs_v[p] = 0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual still running expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] lcg = 32'h1357_9BDF;
    for (int p = 0; p < 4; p++) begin
      en_v[p] = 0; we_v[p] = 0; rs_v[p] = 1; ad_v[p] = '0; dn_v[p] = '0; pn_v[p] = '0;
      last_d[p] = '0; last_p[p] = '0;
    end
    for (int k = 0; k < 2; k++) begin m_d[k] = INIT_D; m_p[k] = INIT_P; end

    for (int p = 0; p < 4; p++) op(p, 0, 0, 1, 0, 0, 0, "R7 reset state");
    op(0, 1, 0, 0, 5, 0, 0, "R8 initial byte");
    op(1, 1, 0, 0, 3, 0, 0, "R8 initial word");
    op(2, 1, 0, 0, 77, 0, 0, "R8 initial bit");
    op(3, 1, 0, 0, 9, 0, 0, "R8 initial half");

    for (int i = 0; i < 4; i++)
      op(0, 1, 1, 0, 8 + i, 32'h11 * (i + 1), 4'(i & 1), "R4 write-first byte");
    op(1, 1, 0, 0, 2, 0, 0, "R2 word built from bytes");
    op(1, 1, 1, 0, 100, 32'hDEAD_BEEF, 4'hA, "R4 write-first word");
    for (int i = 0; i < 4; i++) op(0, 1, 0, 0, 400 + i, 0, 0, "R3 parity per byte lane");

    op(0, 0, 1, 0, 8, 32'hFF, 4'h1, "R6 hold while disabled");
    op(0, 1, 0, 0, 8, 0, 0, "R6 disabled write ignored");
    op(1, 0, 0, 1, 0, 0, 0, "R7 reset clears output");
    op(1, 1, 0, 0, 100, 0, 0, "R7 contents kept");

    op(0, 1, 1, 0, 2047, 32'h5C, 4'h1, "R1 top byte");
    op(1, 1, 0, 0, 511, 0, 0, "R1 top word");

    for (int i = 0; i < 24; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      op(1, 1, 1, 0, 200 + (i % 8), lcg, lcg[3:0], "R9 write on clock B");
      op(0, 1, 0, 0, 4 * (200 + (i % 8)) + int'(lcg[29:28]), 0, 0, "R9 read on clock A");
      op(0, 1, 0, 0, 4 * (200 + (i % 8)) + int'(lcg[31:30]), 0, 0, "R5 read latency");
    end

    for (int i = 0; i < 16; i++)
      op(2, 1, 1, 0, 224 + i, 32'(i % 3 == 0), 4'h1, "R3 narrow parity ignored");
    op(3, 1, 0, 0, 14, 0, 0, "R2 half from bits");
    op(3, 1, 0, 0, 15, 0, 0, "R2 upper half");
    op(3, 1, 1, 0, 20, 32'hA5C3, 4'h2, "R4 half write");
    for (int i = 0; i < 16; i++) op(2, 1, 0, 0, 320 + i, 0, 0, "R2 bit lanes of half");
    op(3, 1, 0, 0, 20, 0, 0, "R3 half parity");

    repeat (4) @(negedge clk_b);
    done = 1;
    summary();
  end
endmodule